// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into an asynchronous serial bit stream on a single transmit line. Software-side logic writes a control word and then a character into a one-entry holding register. When the transmitter is enabled, the holding register is full and the optional clear-to-send input allows it, the character moves into a shift register. It then leaves the line framed by one start bit, an optional parity bit and one or two stop bits. Every bit lasts sixteen periods of an oversampling tick. That tick comes from an external divider of the form f/(16(n+1)) with an 8-bit n.

Several options shape the frame: the character length, the parity mode, the stop-bit count, which end of the character goes out first, and whether the data bits are complemented. A separate polarity option flips the entire line, idle level included. A single interrupt request pulses either when the holding register is emptied into the shift register or when the last stop bit has finished. A character written while a frame is on the line waits in the holding register and follows with no idle gap.

Top module: `uart_tx_engine`

## Requirements
- R1: A write with `wr_sel`=1 loads the control word from `wr_data`. The fields are: bit0 enable, bits2:1 length select, bits4:3 parity select, bit5 two stop bits, bit6 most-significant-first, bit7 data complement, bit8 line polarity invert, bit9 clear-to-send gating, bit10 interrupt on completion. A write with `wr_sel`=0 loads the character from `wr_data[8:0]` and clears `buf_empty`.
- R2: A frame is one start bit (0), then the data bits, then the optional parity bit, then one stop bit (1), or two when bit5 is set. Length select 00 gives 7 data bits, 10 gives 9, and 01 or 11 give 8. Each bit lasts 16 ticks of `tick16`.
- R3: Parity select 10 gives even and 11 gives odd; 00 and 01 send no parity bit. The parity bit is chosen so that the data bits as driven, plus the parity bit, hold an even (or odd) number of ones.
- R4: A frame starts only while enable is 1 and the holding register is full, and, when gating is on, only while `cts_n` is 0. Otherwise the line stays idle and `buf_empty` stays 0.
- R5: `irq` is a one-cycle pulse. With bit10 at 0 it rises together with the start bit, when the holding register is emptied. With bit10 at 1 it rises when the last stop bit has completed.
- R6: With bit6 at 0, data bit 0 is sent first. With bit6 at 1, the highest bit of the selected length is sent first.
- R7: With bit7 set, the data bits are complemented. The start bit stays 0 and the stop bits stay 1. Parity is computed over the complemented bits.
- R8: With bit8 set, `txd` is the complement of the whole waveform, so the idle level becomes 0.
- R9: A character written during a frame is held, and `buf_empty` stays 0. Its start bit follows the last stop bit of the current frame with no idle time between them.
- R10: A character write in the same cycle as the transfer from the holding register keeps the new character. `buf_empty` stays 0, and that character is sent as the next frame.
- R11: After reset, `txd` is 1, `irq` is 0 and `buf_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write strobe |
| wr_sel | input | 1 | 1 selects the control word, 0 the character |
| wr_data | input | 11 | Write value |
| tick16 | input | 1 | One-cycle oversampling tick, 16 per bit |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial line |
| irq | output | 1 | Interrupt request pulse |
| buf_empty | output | 1 | Holding register empty |

## Verification
The transfer from the holding register can coincide with a fresh character write. The bench provokes this with two writes in consecutive cycles on an idle, enabled transmitter, so that the second write lands in the transfer cycle. It judges the result by both frames appearing in order with `buf_empty` still low during the first. A second overlap is the end of a frame meeting a pending load. This is judged by the gap between the two start bits being exactly one frame length.

// File: rtl/uart_tx_engine_pkg.sv
package uart_tx_engine_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    // Field order fixes the bit positions of the control word
    typedef struct packed {
        logic       irq_on_done;
        logic       cts_gate;
        logic       pol_inv;
        logic       data_inv;
        logic       msb_first;
        logic       two_stop;
        logic [1:0] par_mode;
        logic [1:0] len_sel;
        logic       tx_en;
    } tx_cfg_t;

    localparam int CFG_W = $bits(tx_cfg_t);

    function automatic logic [3:0] char_len(input logic [1:0] sel);
        case (sel)
            2'b00:   return 4'd7;
            2'b10:   return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_hold_reg.sv
module uart_tx_hold_reg
    import uart_tx_engine_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int WR_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_sel,
    input  logic [WR_W-1:0]   wr_data,
    input  logic              take,
    output tx_cfg_t           cfg,
    output logic [DATA_W-1:0] hold,
    output logic              empty
);

    typedef struct packed {
        tx_cfg_t           cfg;
        logic [DATA_W-1:0] data;
        logic              empty;
    } hold_s;

    localparam hold_s RST = '{cfg: '0, data: '0, empty: 1'b1};

    hold_s q, d;

    always_comb begin
        d = q;
        if (take) d.empty = 1'b1;
        if (wr_valid) begin
            if (wr_sel) begin
                d.cfg = tx_cfg_t'(wr_data[CFG_W-1:0]);
            end else begin
                d.data  = wr_data[DATA_W-1:0];
                d.empty = 1'b0;   // a write in the transfer cycle wins
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign cfg   = q.cfg;
    assign hold  = q.data;
    assign empty = q.empty;

endmodule

// File: rtl/uart_tx_frame_prep.sv
module uart_tx_frame_prep #(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0] data,
    input  logic [3:0]        len,
    input  logic              msb_first,
    input  logic              data_inv,
    input  logic              par_odd,
    output logic [DATA_W-1:0] bits,
    output logic              par_bit
);

    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    // bits[k] is the k-th data bit to appear on the line
    always_comb begin
        bits = '0;
        for (int i = 0; i < DATA_W; i++) begin
            logic [IW-1:0] idx;
            idx = msb_first ? IW'(int'(len) - 1 - i) : IW'(i);
            if (i < int'(len)) bits[i] = data[idx] ^ data_inv;
        end
        par_bit = (^bits) ^ par_odd;
    end

endmodule

// File: rtl/uart_tx_shift_seq.sv
module uart_tx_shift_seq
    import uart_tx_engine_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              cts_gate,
    input  logic              cts_n,
    input  logic              irq_on_done,
    input  logic              par_en,
    input  logic              two_stop,
    input  logic [3:0]        len,
    input  logic              empty,
    input  logic [DATA_W-1:0] frame_bits,
    input  logic              par_bit,
    output logic              take,
    output logic              busy,
    output logic              line,
    output logic              irq
);

    localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int BW = $clog2(DATA_W + 1);

    typedef struct packed {
        tx_state_e         st;
        logic [TW-1:0]     tcnt;
        logic [BW-1:0]     bcnt;
        logic [BW-1:0]     nlen;
        logic              pen;
        logic              two;
        logic              sidx;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              line;
        logic              irq;
    } seq_s;

    seq_s q, d;
    logic can_go, bit_end, do_load;

    always_comb begin
        d       = q;
        d.irq   = 1'b0;
        take    = 1'b0;
        do_load = 1'b0;
        can_go  = tx_en && !empty && (!cts_gate || !cts_n);
        bit_end = tick && (q.tcnt == TW'(OVS - 1));

        if (q.st != ST_IDLE && tick) d.tcnt = bit_end ? '0 : q.tcnt + 1'b1;

        case (q.st)
            ST_IDLE: do_load = can_go;
            ST_START: if (bit_end) begin
                d.st   = ST_DATA;
                d.bcnt = '0;
            end
            ST_DATA: if (bit_end) begin
                d.sh = q.sh >> 1;
                if (q.bcnt == q.nlen - 1'b1) begin
                    d.st   = q.pen ? ST_PAR : ST_STOP;
                    d.sidx = 1'b0;
                end else begin
                    d.bcnt = q.bcnt + 1'b1;
                end
            end
            ST_PAR: if (bit_end) begin
                d.st   = ST_STOP;
                d.sidx = 1'b0;
            end
            ST_STOP: if (bit_end) begin
                if (q.two && !q.sidx) begin
                    d.sidx = 1'b1;
                end else begin
                    d.st    = ST_IDLE;
                    d.irq   = irq_on_done;
                    do_load = can_go;   // back-to-back frame
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (do_load) begin
            d.st   = ST_START;
            d.tcnt = '0;
            d.bcnt = '0;
            d.nlen = BW'(len);
            d.pen  = par_en;
            d.two  = two_stop;
            d.sh   = frame_bits;
            d.par  = par_bit;
            d.irq  = d.irq | !irq_on_done;
            take   = 1'b1;
        end

        case (d.st)
            ST_START: d.line = 1'b0;
            ST_DATA:  d.line = d.sh[0];
            ST_PAR:   d.line = d.par;
            default:  d.line = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, line: 1'b1, default: '0};
        else        q <= d;
    end

    assign busy = (q.st != ST_IDLE);
    assign line = q.line;
    assign irq  = q.irq;

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_engine_pkg::*;
#(
    parameter  int DATA_W = 9,
    parameter  int OVS    = 16,
    localparam int WR_W   = (CFG_W > DATA_W) ? CFG_W : DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic            wr_sel,
    input  logic [WR_W-1:0] wr_data,
    input  logic            tick16,
    input  logic            cts_n,
    output logic            txd,
    output logic            irq,
    output logic            buf_empty
);

    tx_cfg_t           cfg;
    logic [DATA_W-1:0] hold;
    logic [DATA_W-1:0] frame_bits;
    logic [3:0]        len;
    logic              par_bit, take, busy, line;

    assign len = char_len(cfg.len_sel);

    uart_tx_hold_reg #(.DATA_W(DATA_W), .WR_W(WR_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .take     (take),
        .cfg      (cfg),
        .hold     (hold),
        .empty    (buf_empty)
    );

    uart_tx_frame_prep #(.DATA_W(DATA_W)) u_prep (
        .data      (hold),
        .len       (len),
        .msb_first (cfg.msb_first),
        .data_inv  (cfg.data_inv),
        .par_odd   (cfg.par_mode[0]),
        .bits      (frame_bits),
        .par_bit   (par_bit)
    );

    uart_tx_shift_seq #(.DATA_W(DATA_W), .OVS(OVS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .tx_en       (cfg.tx_en),
        .cts_gate    (cfg.cts_gate),
        .cts_n       (cts_n),
        .irq_on_done (cfg.irq_on_done),
        .par_en      (cfg.par_mode[1]),
        .two_stop    (cfg.two_stop),
        .len         (len),
        .empty       (buf_empty),
        .frame_bits  (frame_bits),
        .par_bit     (par_bit),
        .take        (take),
        .busy        (busy),
        .line        (line),
        .irq         (irq)
    );

    assign txd = line ^ cfg.pol_inv;

endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic wr_sel,
    input logic txd,
    input logic irq,
    input logic buf_empty,
    input logic cts_n,
    input logic busy,
    input logic tx_en,
    input logic cts_gate,
    input logic pol_inv
);

    a_r4_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(tx_en) && !$past(buf_empty)));

    a_r4_cts_respected: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(cts_gate)) |-> !$past(cts_n));

    a_r1_empty_clears_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> $past(wr_valid && !wr_sel));

    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd == !pol_inv));

endmodule

bind uart_tx_engine uart_tx_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_sel    (wr_sel),
    .txd       (txd),
    .irq       (irq),
    .buf_empty (buf_empty),
    .cts_n     (cts_n),
    .busy      (busy),
    .tx_en     (cfg.tx_en),
    .cts_gate  (cfg.cts_gate),
    .pol_inv   (cfg.pol_inv)
);

// File: tb/uart_tx_engine_tb_top.sv
module uart_tx_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_sel = 1'b0;
    logic [10:0] wr_data = '0;
    logic        tick16 = 1'b0;
    logic        cts_n = 1'b0;
    logic        txd, irq, buf_empty;

    int checks = 0, errors = 0, cyc = 0, irq_cnt = 0, irq_cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    uart_tx_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick16(tick16), .cts_n(cts_n),
        .txd(txd), .irq(irq), .buf_empty(buf_empty)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (rst_n && irq) begin
        irq_cnt = irq_cnt + 1;
        irq_cyc = cyc;
    end

    // tick every second cycle: one bit = 32 clocks
    initial forever begin
        @(negedge clk);
        tick16 = ~tick16;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] cfgw(input bit en, input logic [1:0] ln, input logic [1:0] pm,
                                         input bit two, input bit msb, input bit dinv,
                                         input bit pinv, input bit gate, input bit idone);
        return {idone, gate, pinv, dinv, msb, two, pm, ln, en};
    endfunction

    // expected line levels before polarity, index 0 = start bit
    function automatic int exp_frame(input logic [8:0] d, input logic [10:0] c, output logic [15:0] f);
        int len, n, ones, idx;
        logic b;
        len = (c[2:1] == 2'b00) ? 7 : (c[2:1] == 2'b10) ? 9 : 8;
        f = '0; n = 1; ones = 0;
        for (int k = 0; k < len; k++) begin
            idx = c[6] ? len - 1 - k : k;
            b = d[idx] ^ c[7];
            ones += int'(b);
            f[n] = b; n++;
        end
        if (c[4]) begin
            f[n] = logic'(ones % 2) ^ c[3]; n++;
        end
        f[n] = 1'b1; n++;
        if (c[5]) begin f[n] = 1'b1; n++; end
        return n;
    endfunction

    task automatic wr(input bit sel, input logic [10:0] v);
        @(negedge clk);
        wr_valid = 1'b1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic capture(input int nb, input logic pol, output logic [15:0] bits, output int sc);
        int t = 0;
        while (txd !== pol && t < 5000) begin @(negedge clk); t++; end
        sc = cyc;
        bits = '0;
        repeat (16) @(negedge clk);
        bits[0] = txd ^ pol;
        for (int k = 1; k < nb; k++) begin
            repeat (32) @(negedge clk);
            bits[k] = txd ^ pol;
        end
    endtask

    task automatic wait_irq(input int target);
        int t = 0;
        while (irq_cnt < target && t < 5000) begin @(negedge clk); #1; t++; end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(txd === 1'b1, "R11 txd", int'(txd), 1);
        chk(irq === 1'b0, "R11 irq", int'(irq), 0);
        chk(buf_empty === 1'b1, "R11 buf_empty", int'(buf_empty), 1);
    endtask

    task automatic run_frame(input string tag, input logic [10:0] c, input logic [8:0] d);
        logic [15:0] ef, got;
        int nb, sc, base;
        wr(1'b1, c);
        nb = exp_frame(d, c, ef);
        base = irq_cnt;
        wr(1'b0, {2'b00, d});
        capture(nb, c[8], got, sc);
        chk(got == ef, {tag, " frame"}, int'(got), int'(ef));
        repeat (40) @(negedge clk); #1;
        chk(irq_cnt == base + 1, "R5 irq count", irq_cnt - base, 1);
        if (c[10])
            chk(irq_cyc - sc >= 32*nb - 2 && irq_cyc - sc <= 32*nb + 1, "R5 irq at done", irq_cyc - sc, 32*nb);
        else
            chk(irq_cyc == sc, "R5 irq at load", irq_cyc - sc, 0);
        chk(buf_empty === 1'b1, "R1 buffer emptied", int'(buf_empty), 1);
    endtask

    task automatic t_pol();
        logic [10:0] c;
        c = cfgw(1, 2'b01, 2'b00, 0, 0, 0, 1, 0, 0);
        wr(1'b1, c);
        @(negedge clk);
        chk(txd === 1'b0, "R8 idle low", int'(txd), 0);
        run_frame("R8 inverted", c, 9'h096);
    endtask

    task automatic t_gate_en();
        logic [10:0] c;
        logic [15:0] ef, got;
        int nb, sc, bad = 0;
        wr(1'b1, cfgw(0, 2'b01, 2'b10, 0, 0, 0, 0, 0, 0));
        wr(1'b0, 11'h055);
        repeat (300) begin @(negedge clk); if (txd !== 1'b1) bad++; end
        chk(bad == 0, "R4 disabled stays idle", bad, 0);
        chk(buf_empty === 1'b0, "R4 disabled holds data", int'(buf_empty), 0);
        c = cfgw(1, 2'b01, 2'b10, 0, 0, 0, 0, 0, 0);
        nb = exp_frame(9'h055, c, ef);
        wr(1'b1, c);
        capture(nb, 1'b0, got, sc);
        chk(got == ef, "R4 sends after enable", int'(got), int'(ef));
        repeat (40) @(negedge clk);
    endtask

    task automatic t_cts();
        logic [10:0] c;
        logic [15:0] ef, got;
        int nb, sc, bad = 0;
        c = cfgw(1, 2'b01, 2'b11, 0, 0, 0, 0, 1, 0);
        nb = exp_frame(9'h0C8, c, ef);
        @(negedge clk); cts_n = 1'b1;
        wr(1'b1, c);
        wr(1'b0, 11'h0C8);
        repeat (300) begin @(negedge clk); if (txd !== 1'b1) bad++; end
        chk(bad == 0, "R4 cts high blocks", bad, 0);
        chk(buf_empty === 1'b0, "R4 cts holds data", int'(buf_empty), 0);
        cts_n = 1'b0;
        capture(nb, 1'b0, got, sc);
        chk(got == ef, "R4 sends after cts low", int'(got), int'(ef));
        repeat (40) @(negedge clk);
    endtask

    task automatic t_b2b();
        logic [10:0] c;
        logic [15:0] ef, got;
        int nb, sa, sb, base;
        c = cfgw(1, 2'b01, 2'b00, 0, 0, 0, 0, 0, 0);
        nb = exp_frame(9'h0B7, c, ef);
        wr(1'b1, c);
        base = irq_cnt;
        wr(1'b0, 11'h03A);
        repeat (100) @(negedge clk);
        sa = irq_cyc;
        wr(1'b0, 11'h0B7);
        chk(buf_empty === 1'b0, "R9 held while busy", int'(buf_empty), 0);
        wait_irq(base + 2);
        capture(nb, 1'b0, got, sb);
        chk(got == ef, "R9 held frame", int'(got), int'(ef));
        chk(sb - sa >= 32*nb - 2 && sb - sa <= 32*nb + 1, "R9 no idle gap", sb - sa, 32*nb);
        chk(buf_empty === 1'b1, "R9 empty after transfer", int'(buf_empty), 1);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_same();
        logic [10:0] c;
        logic [15:0] ed, ee, got;
        int nb, sc, base;
        c = cfgw(1, 2'b10, 2'b10, 0, 0, 0, 0, 0, 0);
        nb = exp_frame(9'h1A5, c, ed);
        void'(exp_frame(9'h04E, c, ee));
        wr(1'b1, c);
        base = irq_cnt;
        @(negedge clk); wr_valid = 1'b1; wr_sel = 1'b0; wr_data = 11'h1A5;
        @(negedge clk); wr_data = 11'h04E;
        @(negedge clk); wr_valid = 1'b0;
        capture(nb, 1'b0, got, sc);
        chk(got == ed, "R10 first frame", int'(got), int'(ed));
        chk(buf_empty === 1'b0, "R10 second kept", int'(buf_empty), 0);
        wait_irq(base + 2);
        capture(nb, 1'b0, got, sc);
        chk(got == ee, "R10 second frame", int'(got), int'(ee));
        repeat (40) @(negedge clk); #1;
        chk(irq_cnt == base + 2, "R10 irq count", irq_cnt - base, 2);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_frame("R2 8N1",           cfgw(1, 2'b01, 2'b00, 0, 0, 0, 0, 0, 0), 9'h0A5);
        run_frame("R2 len11 is 8",    cfgw(1, 2'b11, 2'b01, 0, 0, 0, 0, 0, 0), 9'h1F0);
        run_frame("R3 7 even",        cfgw(1, 2'b00, 2'b10, 0, 0, 0, 0, 0, 0), 9'h053);
        run_frame("R3 9 odd 2stop",   cfgw(1, 2'b10, 2'b11, 1, 0, 0, 0, 0, 0), 9'h1C3);
        run_frame("R6 msb 8",         cfgw(1, 2'b01, 2'b00, 0, 1, 0, 0, 0, 0), 9'h02D);
        run_frame("R6 msb 9 even",    cfgw(1, 2'b10, 2'b10, 0, 1, 0, 0, 0, 0), 9'h10F);
        run_frame("R7 inv 8 even",    cfgw(1, 2'b01, 2'b10, 0, 0, 1, 0, 0, 0), 9'h071);
        run_frame("R7 inv 7 odd",     cfgw(1, 2'b00, 2'b11, 0, 0, 1, 0, 0, 0), 9'h015);
        run_frame("R5 done 2stop",    cfgw(1, 2'b01, 2'b10, 1, 0, 0, 0, 0, 1), 9'h0E1);
        t_pol();
        t_gate_en();
        t_cts();
        t_b2b();
        t_same();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule